// File: doc/BRIEF.md
# Iterative Shift-Add Multiply Unit

This block multiplies two 32-bit operands over many clock cycles and makes the 64-bit product available as a high word and a low word. It fits into a processor pipeline as a multicycle execution unit. A select input picks between two's-complement and plain unsigned interpretation of both operands.

The datapath keeps the whole product in one 64-bit register. At the start, the low half of that register holds the multiplier. On each iteration the unit looks at the register's least significant bit. If that bit is set, a 32-bit adder adds the multiplicand into the upper half. The register is then shifted right by one place in the same cycle, and the adder's carry becomes the new top bit. After 32 iterations the register holds the product of the two magnitudes.

For a signed request, both operands are first reduced to their magnitudes. The finished 64-bit product is negated when exactly one operand was negative. A start/busy/done handshake sequences each operation.

Top module: `shift_add_mul`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy_o` and `done_o` are low and `hi_o`/`lo_o` read zero.
- R2: With `signed_i` = 0, `{hi_o, lo_o}` equals the unsigned 64-bit product of `mcand_i` and `mplier_i`.
- R3: With `signed_i` = 1, `{hi_o, lo_o}` equals the two's-complement 64-bit product of the operands taken as signed 32-bit values.
- R4: In signed mode, the value 0x80000000 is handled as magnitude 2^31. Examples: 0x80000000 × 0x80000000 gives 0x4000000000000000, and 0x80000000 × 0xFFFFFFFF gives 0x0000000080000000.
- R5: `done_o` rises on the 33rd rising clock edge after the edge that accepts `start_i`. This covers 32 add-and-shift iterations and one result-write cycle.
- R6: A start is accepted on an edge where `start_i` is high and `busy_o` is low. `busy_o` is high from the next cycle until `done_o` rises. `busy_o` is low whenever `done_o` is high.
- R7: `done_o` is high for exactly one cycle per operation.
- R8: A `start_i` pulse while `busy_o` is high is ignored. The running operation completes with its original operands, and no extra `done_o` follows.
- R9: `hi_o` and `lo_o` keep the previous result for the whole operation and change only in the cycle where `done_o` rises.
- R10: Carries out of the upper-half adder are not lost. For example, unsigned 0xFFFFFFFF × 0xFFFFFFFF gives 0xFFFFFFFE00000001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a multiply; sampled only while idle |
| signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| mcand_i | input | 32 | Multiplicand, sampled on the accepting edge |
| mplier_i | input | 32 | Multiplier, sampled on the accepting edge |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse: new result on hi_o/lo_o |
| hi_o | output | 32 | Upper 32 bits of the last product |
| lo_o | output | 32 | Lower 32 bits of the last product |

## Verification
Several internal faults show up at the ports in recognisable ways:
- A dropped adder carry, a wrong shift direction or a lost multiplier bit corrupts `{hi_o, lo_o}` in the very `done_o` cycle. Operands with many set bits, and the all-ones case, expose this at once.
- A miscounted iteration or a state-machine slip moves `done_o` away from the 33rd edge, so the exact latency check catches it within one operation.
- A sign-correction fault appears only for mixed-sign and most-negative operands.
- A missing busy guard appears as a changed result or an extra `done_o` after a start pulse issued during busy.

// File: rtl/mul_pkg.sv
package mul_pkg;

    localparam int unsigned MUL_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } mul_state_e;

    // Magnitude of a 32-bit operand; signed minimum maps to 2^31 unsigned.
    function automatic logic [MUL_W-1:0] op_mag(input logic [MUL_W-1:0] v, input logic is_signed);
        if (is_signed && v[MUL_W-1])
            return (~v) + 1'b1;
        return v;
    endfunction

    // Two's-complement negation of the double-width product.
    function automatic logic [2*MUL_W-1:0] prod_neg(input logic [2*MUL_W-1:0] p);
        return (~p) + 1'b1;
    endfunction

endpackage

// File: rtl/mul_operand_prep.sv
module mul_operand_prep
    import mul_pkg::*;
#(
    parameter int unsigned W = MUL_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         signed_i,
    output logic [W-1:0] a_mag_o,
    output logic [W-1:0] b_mag_o,
    output logic         neg_o
);
    localparam int unsigned MSB = W - 1;

    logic a_neg, b_neg;

    always_comb begin
        a_neg = signed_i & a_i[MSB];
        b_neg = signed_i & b_i[MSB];
        a_mag_o = a_neg ? ((~a_i) + 1'b1) : a_i;
        b_mag_o = b_neg ? ((~b_i) + 1'b1) : b_i;
        neg_o   = a_neg ^ b_neg;
    end
endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
    import mul_pkg::*;
#(
    parameter int unsigned ITER = MUL_W
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic fin_o,
    output logic busy_o
);
    localparam int unsigned CW = $clog2(ITER);
    localparam logic [CW-1:0] LAST = CW'(ITER - 1);

    mul_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_RUN;
            ST_RUN:    if (cnt_q == LAST) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RUN)
                cnt_q <= cnt_q + 1'b1;
            else
                cnt_q <= '0;
        end
    end

    assign load_o = (state_q == ST_IDLE) & start_i;
    assign step_o = (state_q == ST_RUN);
    assign fin_o  = (state_q == ST_FINISH);
    assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/mul_addshift.sv
module mul_addshift
    import mul_pkg::*;
#(
    parameter int unsigned W = MUL_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load_i,
    input  logic           step_i,
    input  logic [W-1:0]   mcand_i,
    input  logic [W-1:0]   mplier_i,
    output logic [2*W-1:0] prod_o
);
    localparam int unsigned PW = 2 * W;

    logic [PW-1:0] prod_q;
    logic [W-1:0]  mcand_q;
    logic [W:0]    upper_sum;
    logic [W-1:0]  addend;

    always_comb begin
        addend    = prod_q[0] ? mcand_q : '0;
        upper_sum = {1'b0, prod_q[PW-1:W]} + {1'b0, addend};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q  <= '0;
            mcand_q <= '0;
        end else if (load_i) begin
            prod_q  <= {{W{1'b0}}, mplier_i};
            mcand_q <= mcand_i;
        end else if (step_i) begin
            // carry becomes bit PW-1, low half loses its tested bit
            prod_q <= {upper_sum, prod_q[W-1:1]};
        end
    end

    assign prod_o = prod_q;
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul
    import mul_pkg::*;
#(
    parameter int unsigned W = MUL_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         signed_i,
    input  logic [W-1:0] mcand_i,
    input  logic [W-1:0] mplier_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] hi_o,
    output logic [W-1:0] lo_o
);
    localparam int unsigned PW = 2 * W;

    logic [W-1:0]  a_mag, b_mag;
    logic          neg_d, neg_q;
    logic          load, step, fin;
    logic [PW-1:0] prod;
    logic [PW-1:0] result;
    logic          done_q;
    logic [W-1:0]  hi_q, lo_q;

    mul_operand_prep #(.W(W)) u_prep (
        .a_i      (mcand_i),
        .b_i      (mplier_i),
        .signed_i (signed_i),
        .a_mag_o  (a_mag),
        .b_mag_o  (b_mag),
        .neg_o    (neg_d)
    );

    mul_ctrl #(.ITER(W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .load_o  (load),
        .step_o  (step),
        .fin_o   (fin),
        .busy_o  (busy_o)
    );

    mul_addshift #(.W(W)) u_dp (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load),
        .step_i   (step),
        .mcand_i  (a_mag),
        .mplier_i (b_mag),
        .prod_o   (prod)
    );

    assign result = neg_q ? ((~prod) + 1'b1) : prod;

    always_ff @(posedge clk) begin
        if (rst) begin
            neg_q  <= 1'b0;
            done_q <= 1'b0;
            hi_q   <= '0;
            lo_q   <= '0;
        end else begin
            if (load) neg_q <= neg_d;
            done_q <= fin;
            if (fin) begin
                hi_q <= result[PW-1:W];
                lo_q <= result[W-1:0];
            end
        end
    end

    assign done_o = done_q;
    assign hi_o   = hi_q;
    assign lo_o   = lo_q;
endmodule

// File: rtl/shift_add_mul_chk.sv
module shift_add_mul_chk #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         start_i,
    input logic         signed_i,
    input logic [W-1:0] mcand_i,
    input logic [W-1:0] mplier_i,
    input logic         busy_o,
    input logic         done_o,
    input logic [W-1:0] hi_o,
    input logic [W-1:0] lo_o
);
    localparam int unsigned PW = 2 * W;
    localparam int unsigned LAT = W + 1;
    localparam int unsigned CW = $clog2(LAT + 2) + 1;

    logic [CW-1:0] edges_q;
    logic [W-1:0]  a_q, b_q;
    logic          s_q;
    logic [PW-1:0] exp_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            edges_q <= '0;
            a_q <= '0;
            b_q <= '0;
            s_q <= 1'b0;
        end else if (start_i && !busy_o) begin
            edges_q <= '0;
            a_q <= mcand_i;
            b_q <= mplier_i;
            s_q <= signed_i;
        end else if (busy_o) begin
            edges_q <= edges_q + 1'b1;
        end
    end

    always_comb begin
        if (s_q)
            exp_v = PW'($signed({{W{a_q[W-1]}}, a_q}) * $signed({{W{b_q[W-1]}}, b_q}));
        else
            exp_v = {{W{1'b0}}, a_q} * {{W{1'b0}}, b_q};
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done_o |=> !done_o);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (rst) done_o |-> !busy_o);

    // R6
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst) (start_i && !busy_o) |=> busy_o);

    // R5
    latency_chk: assert property (@(posedge clk) disable iff (rst) done_o |-> (edges_q == CW'(LAT)));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done_o |=> (!done_o || 1'b1) && ((done_o) || ($stable(hi_o) && $stable(lo_o))));

    // R2 R3
    product_chk: assert property (@(posedge clk) disable iff (rst) done_o |-> ({hi_o, lo_o} == exp_v));
endmodule

bind shift_add_mul shift_add_mul_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .signed_i (signed_i),
    .mcand_i  (mcand_i),
    .mplier_i (mplier_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .hi_o     (hi_o),
    .lo_o     (lo_o)
);

// File: tb/shift_add_mul_tb.sv
module shift_add_mul_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        signed_i = 1'b0;
    logic [31:0] mcand_i = '0;
    logic [31:0] mplier_i = '0;
    logic        busy_o, done_o;
    logic [31:0] hi_o, lo_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] last_res = '0;

    always #4 clk = ~clk;  // 125 MHz

    shift_add_mul u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .signed_i(signed_i),
        .mcand_i(mcand_i), .mplier_i(mplier_i),
        .busy_o(busy_o), .done_o(done_o), .hi_o(hi_o), .lo_o(lo_o)
    );

    function automatic logic [63:0] ref_mul(input logic [31:0] a, input logic [31:0] b, input logic s);
        logic [63:0] ax, bx;
        ax = s ? {{32{a[31]}}, a} : {32'b0, a};
        bx = s ? {{32{b[31]}}, b} : {32'b0, b};
        return ax * bx;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // inject: issue a foreign start at iteration 10 while busy (R8)
    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic s,
                          input string req, input bit inject);
        logic [63:0] exp;
        int lat;
        bit seen;
        exp = ref_mul(a, b, s);
        @(negedge clk);
        start_i = 1'b1; signed_i = s; mcand_i = a; mplier_i = b;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        seen = 0;
        // R6: busy right after accept
        check(busy_o == 1'b1, "R6 busy after accept", {63'b0, busy_o}, 64'd1);
        while (lat < 60 && !seen) begin
            if (done_o) begin
                seen = 1;
            end else begin
                if (lat == 10) begin
                    // R9: previous result still on hi/lo mid-operation
                    check({hi_o, lo_o} == last_res, "R9 hold", {hi_o, lo_o}, last_res);
                    if (inject) begin
                        start_i = 1'b1; signed_i = ~s; mcand_i = ~a; mplier_i = a ^ b ^ 32'h5A5A_0F0F;
                    end
                end else begin
                    start_i = 1'b0;
                end
                @(negedge clk);
                lat++;
            end
        end
        start_i = 1'b0;
        // done seen at negedge after edge 33 following the accept edge -> lat 34
        check(seen && lat == 34, "R5 latency", 64'(lat), 64'd34);
        check({hi_o, lo_o} == exp, req, {hi_o, lo_o}, exp);
        check(busy_o == 1'b0, "R6 idle at done", {63'b0, busy_o}, 64'd0);
        last_res = exp;
        @(negedge clk);
        check(done_o == 1'b0, "R7 single pulse", {63'b0, done_o}, 64'd0);
        if (inject) begin
            // R8: no second completion and result unchanged
            repeat (40) begin
                @(negedge clk);
                if (done_o || busy_o) check(1'b0, "R8 ignored start", {62'b0, busy_o, done_o}, 64'd0);
            end
            check({hi_o, lo_o} == exp, "R8 result kept", {hi_o, lo_o}, exp);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        logic [31:0] ra, rb;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 during reset
        check(!busy_o && !done_o && hi_o == 0 && lo_o == 0, "R1 reset", {hi_o, lo_o}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy_o && !done_o && hi_o == 0 && lo_o == 0, "R1 after reset", {hi_o, lo_o}, 64'd0);

        run_op(32'd21, 32'd5, 1'b0, "R2 small unsigned", 0);
        run_op(32'd0, 32'hDEAD_BEEF, 1'b0, "R2 zero", 0);
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R10 all ones carry", 0);
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R3 minus one squared", 0);
        run_op(32'hFFFF_FFF9, 32'd6, 1'b1, "R3 mixed sign", 0);
        run_op(32'd7, 32'h8000_0001, 1'b1, "R3 positive by negative", 0);
        run_op(32'h8000_0000, 32'h8000_0000, 1'b1, "R4 min squared", 0);
        run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R4 min by minus one", 0);
        run_op(32'h8000_0000, 32'd1, 1'b1, "R4 min by one", 0);
        run_op(32'h8000_0000, 32'h8000_0000, 1'b0, "R2 unsigned top bit", 0);
        run_op(32'h1234_5678, 32'h9ABC_DEF0, 1'b0, "R8 busy start run", 1);
        run_op(32'hCAFE_F00D, 32'h0BAD_C0DE, 1'b1, "R8 busy start signed", 1);

        for (int i = 0; i < 60; i++) begin
            ra = $urandom();
            rb = $urandom();
            run_op(ra, rb, i[0], i[0] ? "R3 random" : "R2 random", 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule